// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the 32-bit status and control word of a floating-point unit. On each operation the arithmetic unit presents a set of exception events (invalid operation, overflow, underflow, divide by zero and inexact), together with two rounding indications and a result-class code. The register accumulates the exceptions in sticky bits and derives three summary bits from them. It decides in the same cycle whether the destination register may be written. One cycle later it raises a trap request if any of the events had its trap enable set.

The trap enables, a flush-to-zero (non-IEEE) mode bit and a 2-bit rounding mode are held in the same word and are brought out as control outputs. Software can replace the word with a write or clear selected bits with a mask. The enables in force are always the ones registered before the event cycle, so a change of control affects only later operations.

Top module: `fpu_stat_ctrl`

Field layout, bit 0 upwards:
- bits 4:0 are the sticky exceptions: invalid, overflow, underflow, zero-divide, inexact.
- bit 5 is the overall summary.
- bit 6 is the enabled summary.
- bit 7 is the invalid summary.
- bit 8 is fraction-rounded and bit 9 is fraction-inexact.
- bits 14:10 hold the result class.
- bits 19:15 are the trap enables, in the same order as the sticky bits.
- bit 20 is non-IEEE mode.
- bits 22:21 are the rounding mode.
- bits 31:23 always read as zero.

## Requirements
- R1: After reset every bit of `regOut` is zero, and `trapReq` and `destWrEn` are low.
- R2: When an event arrives on `evValid` with exception bit k set and enable k clear, sticky bit k is set on the next cycle, `destWrEn` is high in the event cycle, and `trapReq` stays low.
- R3: Bit 7 (invalid summary) always equals sticky bit 0 (invalid).
- R4: Bit 6 (enabled summary) is the OR, over k, of sticky bit k AND enable bit 15+k. Writes to bit 6 have no effect.
- R5: An event with an enabled overflow, underflow or inexact exception keeps `destWrEn` high in the event cycle. `trapReq` goes high in the following cycle.
- R6: An event with an enabled invalid or zero-divide exception drives `destWrEn` low in the event cycle. `trapReq` goes high in the following cycle.
- R7: Every event overwrites bits 8, 9 and 14:10 with `evFracRnd`, `evFracInx` and `evClass`.
- R8: Bit 5 (overall summary) is set by an event only when at least one sticky bit goes from 0 to 1. Otherwise it keeps the value software left in it.
- R9: A software write that lands in the same cycle as an event does not change that event's trap or write-back decision.
- R10: A software write loads bits 5, 4:0 and 22:8 from `swWrData`. Bits 7:6 and 31:23 ignore the written data.
- R11: A bit-clear sets to zero every writable bit whose mask bit is 1.
- R12: When a software write or clear and an event hit the same cycle, the event's sticky bits end up set.
- R13: Without `evValid`, `destWrEn` is low and on the next cycle `trapReq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evValid | input | 1 | An operation completes this cycle |
| evExc | input | 5 | Exception events: invalid, overflow, underflow, zero-divide, inexact (bit 0 up) |
| evFracRnd | input | 1 | Fraction was rounded up |
| evFracInx | input | 1 | Fraction is inexact |
| evClass | input | 5 | Result-class code |
| swWrEn | input | 1 | Software full-word write |
| swWrData | input | 32 | Software write data |
| swClrEn | input | 1 | Software bit-clear |
| swClrMask | input | 32 | Bits to clear |
| regOut | output | 32 | Current register word |
| trapEnOut | output | 5 | Trap enables |
| nonIeeeOut | output | 1 | Non-IEEE mode |
| rndModeOut | output | 2 | Rounding mode |
| trapReq | output | 1 | Trap request, one cycle after the trapping event |
| destWrEn | output | 1 | Destination write enable for the current event |

## Verification
The checker covers the properties that hold on every cycle:
- the two derived summary bits against the sticky bits and enables;
- the sticky set following each event;
- the one-cycle trap request after an enabled exception;
- write-back suppression for invalid and zero-divide;
- the quiet outputs when no event is present.

Only the bench scenarios can show the rest:
- the overall summary staying clear when an event repeats an exception that is already sticky;
- a same-cycle control write that does not affect the event it overlaps;
- the exact result of software writes and clears that collide with events.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int REG_W   = 32;
  localparam int EXC_N   = 5;
  localparam int CLS_W   = 5;
  localparam int RM_W    = 2;

  localparam int EX_INV  = 0;
  localparam int EX_OVF  = 1;
  localparam int EX_UNF  = 2;
  localparam int EX_ZDV  = 3;
  localparam int EX_INX  = 4;

  localparam int STK_LO  = 0;
  localparam int SUM_ALL = STK_LO + EXC_N;
  localparam int SUM_EN  = SUM_ALL + 1;
  localparam int SUM_INV = SUM_EN + 1;
  localparam int FR_BIT  = SUM_INV + 1;
  localparam int FI_BIT  = FR_BIT + 1;
  localparam int CLS_LO  = FI_BIT + 1;
  localparam int EN_LO   = CLS_LO + CLS_W;
  localparam int NI_BIT  = EN_LO + EXC_N;
  localparam int RM_LO   = NI_BIT + 1;
  localparam int USED_W  = RM_LO + RM_W;

  // exceptions whose enabled form blocks the destination write
  localparam logic [EXC_N-1:0] NO_WB_MASK = (EXC_N'(1) << EX_INV) | (EXC_N'(1) << EX_ZDV);

  typedef struct packed {
    logic [EXC_N-1:0] hwSet;
    logic             setSummary;
    logic             loadResult;
  } fsc_strobe_t;
endpackage

// File: rtl/fsc_ctrl.sv
module fsc_ctrl
  import fsc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             evValid,
  input  logic [EXC_N-1:0] evExc,
  input  logic [EXC_N-1:0] stickyCur,
  input  logic [EXC_N-1:0] enableCur,
  output fsc_strobe_t      strobe,
  output logic             trapReq,
  output logic             destWrEn
);
  logic [EXC_N-1:0] hwSet;
  logic [EXC_N-1:0] enHit;
  logic [EXC_N-1:0] blockWb;
  logic             trapNext;

  assign hwSet = evValid ? evExc : '0;
  assign enHit = hwSet & enableCur;

  for (genvar k = 0; k < EXC_N; k++) begin : g_wbClass
    if (NO_WB_MASK[k]) begin : g_block
      assign blockWb[k] = enHit[k];
    end else begin : g_pass
      assign blockWb[k] = 1'b0;
    end
  end

  assign trapNext = |enHit;
  assign destWrEn = evValid & ~(|blockWb);

  always_comb begin
    strobe.hwSet      = hwSet;
    strobe.setSummary = |(hwSet & ~stickyCur);
    strobe.loadResult = evValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trapReq <= 1'b0;
    else       trapReq <= trapNext;
  end
endmodule

// File: rtl/fsc_datapath.sv
module fsc_datapath
  import fsc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  fsc_strobe_t      strobe,
  input  logic             evFracRnd,
  input  logic             evFracInx,
  input  logic [CLS_W-1:0] evClass,
  input  logic             swWrEn,
  input  logic [REG_W-1:0] swWrData,
  input  logic             swClrEn,
  input  logic [REG_W-1:0] swClrMask,
  output logic [REG_W-1:0] regOut,
  output logic [EXC_N-1:0] stickyCur,
  output logic [EXC_N-1:0] enableCur,
  output logic             nonIeeeCur,
  output logic [RM_W-1:0]  rndModeCur
);
  logic [EXC_N-1:0] stickyQ, enableQ;
  logic             summaryQ, fracRndQ, fracInxQ, nonIeeeQ;
  logic [CLS_W-1:0] classQ;
  logic [RM_W-1:0]  rndModeQ;

  logic [REG_W-1:0] wrImg, swImg;
  logic [EXC_N-1:0] stickyD;

  always_comb begin
    regOut = '0;
    regOut[STK_LO +: EXC_N] = stickyQ;
    regOut[SUM_ALL]         = summaryQ;
    regOut[SUM_EN]          = |(stickyQ & enableQ);
    regOut[SUM_INV]         = stickyQ[EX_INV];
    regOut[FR_BIT]          = fracRndQ;
    regOut[FI_BIT]          = fracInxQ;
    regOut[CLS_LO +: CLS_W] = classQ;
    regOut[EN_LO +: EXC_N]  = enableQ;
    regOut[NI_BIT]          = nonIeeeQ;
    regOut[RM_LO +: RM_W]   = rndModeQ;
  end

  // software view: write first, then clear
  assign wrImg = swWrEn ? swWrData : regOut;
  assign swImg = swClrEn ? (wrImg & ~swClrMask) : wrImg;

  for (genvar k = 0; k < EXC_N; k++) begin : g_sticky
    assign stickyD[k] = swImg[STK_LO + k] | strobe.hwSet[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stickyQ  <= '0;
      summaryQ <= 1'b0;
      fracRndQ <= 1'b0;
      fracInxQ <= 1'b0;
      classQ   <= '0;
      enableQ  <= '0;
      nonIeeeQ <= 1'b0;
      rndModeQ <= '0;
    end else begin
      stickyQ  <= stickyD;
      summaryQ <= strobe.setSummary | swImg[SUM_ALL];
      enableQ  <= swImg[EN_LO +: EXC_N];
      nonIeeeQ <= swImg[NI_BIT];
      rndModeQ <= swImg[RM_LO +: RM_W];
      if (strobe.loadResult) begin
        fracRndQ <= evFracRnd;
        fracInxQ <= evFracInx;
        classQ   <= evClass;
      end else begin
        fracRndQ <= swImg[FR_BIT];
        fracInxQ <= swImg[FI_BIT];
        classQ   <= swImg[CLS_LO +: CLS_W];
      end
    end
  end

  assign stickyCur  = stickyQ;
  assign enableCur  = enableQ;
  assign nonIeeeCur = nonIeeeQ;
  assign rndModeCur = rndModeQ;
endmodule

// File: rtl/fpu_stat_ctrl.sv
module fpu_stat_ctrl
  import fsc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        evValid,
  input  logic [4:0]  evExc,
  input  logic        evFracRnd,
  input  logic        evFracInx,
  input  logic [4:0]  evClass,
  input  logic        swWrEn,
  input  logic [31:0] swWrData,
  input  logic        swClrEn,
  input  logic [31:0] swClrMask,
  output logic [31:0] regOut,
  output logic [4:0]  trapEnOut,
  output logic        nonIeeeOut,
  output logic [1:0]  rndModeOut,
  output logic        trapReq,
  output logic        destWrEn
);
  fsc_strobe_t      strobe;
  logic [EXC_N-1:0] stickyCur, enableCur;

  fsc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evExc(evExc),
    .stickyCur(stickyCur), .enableCur(enableCur),
    .strobe(strobe), .trapReq(trapReq), .destWrEn(destWrEn)
  );

  fsc_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .evFracRnd(evFracRnd), .evFracInx(evFracInx), .evClass(evClass),
    .swWrEn(swWrEn), .swWrData(swWrData), .swClrEn(swClrEn), .swClrMask(swClrMask),
    .regOut(regOut), .stickyCur(stickyCur), .enableCur(enableCur),
    .nonIeeeCur(nonIeeeOut), .rndModeCur(rndModeOut)
  );

  assign trapEnOut = enableCur;
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker (
  input logic        clk,
  input logic        rstN,
  input logic        evValid,
  input logic [4:0]  evExc,
  input logic [31:0] regOut,
  input logic [4:0]  trapEnOut,
  input logic        trapReq,
  input logic        destWrEn
);
  assert_sticky_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    evValid |=> ((regOut[4:0] & $past(evExc)) == $past(evExc)));

  assert_inv_summary_R3: assert property (@(posedge clk) disable iff (!rstN)
    regOut[7] == regOut[0]);

  assert_en_summary_R4: assert property (@(posedge clk) disable iff (!rstN)
    regOut[6] == |(regOut[4:0] & regOut[19:15]));

  // R5 and R6: any enabled exception gives a trap one cycle later
  assert_trap_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && |(evExc & trapEnOut)) |=> trapReq);

  assert_wb_blocked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && ((evExc[0] && trapEnOut[0]) || (evExc[3] && trapEnOut[3]))) |-> !destWrEn);

  assert_quiet_wb_R13: assert property (@(posedge clk) disable iff (!rstN)
    !evValid |-> !destWrEn);

  assert_quiet_trap_R13: assert property (@(posedge clk) disable iff (!rstN)
    !evValid |=> !trapReq);

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    regOut[31:23] == '0);
endmodule

bind fpu_stat_ctrl fsc_checker chk_i (
  .clk(clk), .rstN(rstN), .evValid(evValid), .evExc(evExc), .regOut(regOut),
  .trapEnOut(trapEnOut), .trapReq(trapReq), .destWrEn(destWrEn)
);

// File: tb/fpu_stat_ctrl_tb_top.sv
module fpu_stat_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evValid = 1'b0;
  logic [4:0]  evExc = '0;
  logic        evFracRnd = 1'b0;
  logic        evFracInx = 1'b0;
  logic [4:0]  evClass = '0;
  logic        swWrEn = 1'b0;
  logic [31:0] swWrData = '0;
  logic        swClrEn = 1'b0;
  logic [31:0] swClrMask = '0;
  logic [31:0] regOut;
  logic [4:0]  trapEnOut;
  logic        nonIeeeOut;
  logic [1:0]  rndModeOut;
  logic        trapReq;
  logic        destWrEn;

  int total = 0;
  int bad = 0;
  logic wbSeen;

  fpu_stat_ctrl dut_i (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evExc(evExc),
    .evFracRnd(evFracRnd), .evFracInx(evFracInx), .evClass(evClass),
    .swWrEn(swWrEn), .swWrData(swWrData), .swClrEn(swClrEn), .swClrMask(swClrMask),
    .regOut(regOut), .trapEnOut(trapEnOut), .nonIeeeOut(nonIeeeOut),
    .rndModeOut(rndModeOut), .trapReq(trapReq), .destWrEn(destWrEn)
  );

  always #5 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle with optional event and software access; wbSeen holds destWrEn
  task automatic cycle(input logic ev, input logic [4:0] exc, input logic fr, input logic fi,
                       input logic [4:0] cls, input logic wr, input logic [31:0] wd,
                       input logic clr, input logic [31:0] cm);
    evValid = ev; evExc = exc; evFracRnd = fr; evFracInx = fi; evClass = cls;
    swWrEn = wr; swWrData = wd; swClrEn = clr; swClrMask = cm;
    #1;
    wbSeen = destWrEn;
    @(posedge clk); #1;
    evValid = 1'b0; swWrEn = 1'b0; swClrEn = 1'b0;
  endtask

  task automatic ev(input logic [4:0] exc, input logic fr, input logic fi, input logic [4:0] cls);
    cycle(1'b1, exc, fr, fi, cls, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic swWrite(input logic [31:0] d);
    cycle(1'b0, '0, 1'b0, 1'b0, '0, 1'b1, d, 1'b0, '0);
  endtask

  task automatic swClear(input logic [31:0] m);
    cycle(1'b0, '0, 1'b0, 1'b0, '0, 1'b0, '0, 1'b1, m);
  endtask

  task automatic t_reset;
    chk(regOut == 32'h0, "R1 reg", regOut, 32'h0);
    chk(!trapReq && !destWrEn, "R1 trap/wb", {trapReq, destWrEn}, 0);
  endtask

  task automatic t_untrapped;
    ev(5'b00010, 1'b1, 1'b1, 5'h11);
    chk(wbSeen == 1'b1, "R2 wb", wbSeen, 1);
    chk(regOut == 32'h4722, "R2 R7 reg", regOut, 32'h4722);
    chk(trapReq == 1'b0, "R2 no trap", trapReq, 0);
  endtask

  task automatic t_invSummary;
    ev(5'b00001, 1'b0, 1'b0, 5'h02);
    chk(regOut == 32'h08A3, "R3 R7 reg", regOut, 32'h08A3);
  endtask

  task automatic t_summaryEdge;
    swClear(32'h20);
    chk(regOut == 32'h0883, "R11 clear summary", regOut, 32'h0883);
    ev(5'b00001, 1'b0, 1'b0, 5'h02);
    chk(regOut == 32'h0883, "R8 repeat no summary", regOut, 32'h0883);
    ev(5'b01000, 1'b0, 1'b0, 5'h02);
    chk(regOut == 32'h08AB, "R8 new bit sets summary", regOut, 32'h08AB);
  endtask

  task automatic t_write;
    swWrite(32'hFFFF_FFFF);
    chk(regOut == 32'h007F_FFFF, "R10 write ones", regOut, 32'h007F_FFFF);
    chk({trapEnOut, nonIeeeOut, rndModeOut} == 8'hFF, "R10 controls",
        {trapEnOut, nonIeeeOut, rndModeOut}, 8'hFF);
    swWrite(32'hFF80_00C0);
    chk(regOut == 32'h0, "R4 R10 read-only bits ignore write", regOut, 32'h0);
  endtask

  task automatic t_clear;
    swWrite(32'h0060_0003);
    chk(regOut == 32'h0060_0083, "R10 partial write", regOut, 32'h0060_0083);
    swClear(32'h0040_0001);
    chk(regOut == 32'h0020_0002, "R11 masked clear", regOut, 32'h0020_0002);
  endtask

  task automatic t_enabledWb;
    swWrite(32'h0001_0000);
    ev(5'b00010, 1'b0, 1'b0, 5'h00);
    chk(wbSeen == 1'b1, "R5 wb kept", wbSeen, 1);
    chk(trapReq == 1'b1, "R5 trap", trapReq, 1);
    chk(regOut == 32'h0001_0062, "R4 R5 reg", regOut, 32'h0001_0062);
  endtask

  task automatic t_enabledBlock;
    swWrite(32'h0004_8000);
    ev(5'b01000, 1'b0, 1'b0, 5'h00);
    chk(wbSeen == 1'b0, "R6 zdiv wb blocked", wbSeen, 0);
    chk(trapReq == 1'b1, "R6 zdiv trap", trapReq, 1);
    chk(regOut == 32'h0004_8068, "R6 zdiv reg", regOut, 32'h0004_8068);
    ev(5'b00001, 1'b0, 1'b0, 5'h00);
    chk(wbSeen == 1'b0, "R6 inv wb blocked", wbSeen, 0);
    chk(trapReq == 1'b1, "R6 inv trap", trapReq, 1);
    chk(regOut == 32'h0004_80E9, "R6 inv reg", regOut, 32'h0004_80E9);
    cycle(1'b0, 5'b11111, 1'b1, 1'b1, 5'h1F, 1'b0, '0, 1'b0, '0);
    chk(wbSeen == 1'b0 && trapReq == 1'b0, "R13 idle", {wbSeen, trapReq}, 0);
    chk(regOut == 32'h0004_80E9, "R13 idle no change", regOut, 32'h0004_80E9);
  endtask

  task automatic t_laterOnly;
    swWrite(32'h0);
    cycle(1'b1, 5'b00001, 1'b0, 1'b0, 5'h00, 1'b1, 32'h0000_8000, 1'b0, '0);
    chk(wbSeen == 1'b1, "R9 same-cycle enable no block", wbSeen, 1);
    chk(trapReq == 1'b0, "R9 same-cycle enable no trap", trapReq, 0);
    chk(regOut == 32'h0000_80E1, "R9 R12 reg", regOut, 32'h0000_80E1);
    ev(5'b00001, 1'b0, 1'b0, 5'h00);
    chk(wbSeen == 1'b0 && trapReq == 1'b1, "R9 later event traps", {wbSeen, trapReq}, 1);
  endtask

  task automatic t_collision;
    cycle(1'b1, 5'b00010, 1'b0, 1'b0, 5'h00, 1'b1, 32'h0, 1'b0, '0);
    chk(regOut == 32'h0000_0022, "R12 write vs event", regOut, 32'h22);
    cycle(1'b1, 5'b00010, 1'b0, 1'b0, 5'h00, 1'b0, '0, 1'b1, 32'h0000_0002);
    chk(regOut == 32'h0000_0022, "R12 clear vs event", regOut, 32'h22);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    t_reset();
    @(posedge clk); #1;
    t_untrapped();
    t_invSummary();
    t_summaryEdge();
    t_write();
    t_clear();
    t_enabledWb();
    t_enabledBlock();
    t_laterOnly();
    t_collision();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule